// File: doc/BRIEF.md
# Frame-Slave Serial Payload Input

This block is the transmit-side serial payload input of an E3-style framer that runs as a frame slave. A single external clock (nominally 34.368 MHz) is shared by the payload source and this block. The source drives a serial data line and, once per frame, a one-bit-wide start-of-frame reference pulse. The block samples both on the rising clock edge and restarts its frame bit counter at each rising edge of the reference. From that counter it classifies every bit position as overhead or payload.

The framer owns the overhead positions, so the source must not place payload there. The block warns the source through a combinational indicator during the bit period just before each overhead position. The source responds by holding back its next payload bit by one clock. Serial input during overhead positions is discarded. Payload bits are presented one clock after sampling, with a valid flag and their position in the frame.

A reference pulse that arrives away from the expected frame boundary forces the counter back to position zero and sets a sticky flag. The flag stays set until reset. The reference is required to be synchronous to the clock, so it is not resynchronized.

Top module: `e3_slave_payload_in`

## Requirements
- R1: After reset, until the first rising edge of `fref_in`, `oh_warn`, `pay_valid` and `realign_seen` stay low, whatever `ser_in` does.
- R2: The bit sampled in the cycle where `fref_in` is high and was low in the previous cycle is frame position 0. A reference held high for several cycles restarts the frame only once, at its first cycle.
- R3: Positions 0 to OH_BITS-1 (default 0..11) are overhead. For those positions `pay_valid` is low one cycle later and `ser_in` is ignored.
- R4: For a payload position (OH_BITS to FRAME_BITS-1), `pay_valid` is high one cycle after the sampling edge, and `pay_bit` equals the `ser_in` value sampled at that edge.
- R5: `pay_pos` shows the frame position of the bit sampled at the previous edge. Without a new reference, positions run 0..FRAME_BITS-1 (default 1535) and then wrap to 0.
- R6: `oh_warn` is high during a cycle exactly when the block is framing and the position that follows the current one is an overhead position. This includes the reference cycle itself.
- R7: A reference rising edge while framing, when the expected next position is not 0, sets `realign_seen`. A reference exactly at the expected frame boundary, or the first reference after reset, does not set it.
- R8: `realign_seen`, once set, stays set until reset, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bit clock, rising-edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Serial payload data from the source |
| fref_in | input | 1 | Start-of-frame reference, one bit wide, synchronous to clk |
| oh_warn | output | 1 | High one bit period before each overhead position |
| pay_valid | output | 1 | Captured bit is payload |
| pay_bit | output | 1 | Captured payload bit |
| pay_pos | output | $clog2(FRAME_BITS) | Frame position of the captured bit |
| realign_seen | output | 1 | Sticky flag for a mid-frame realignment |

## Verification
A counter that is off by one or has lost alignment shows up within one cycle as a wrong `pay_pos`. It also shows up within the next overhead region as `oh_warn` appearing one cycle early or late, and `pay_valid` rising at the wrong position. A faulty edge detector or a bad run flag shows up in the reference cycle itself: either no restart at position 0, or a restart on each cycle of a held reference. A broken sticky flag shows up at the first mid-frame pulse, or as a flag set by a pulse that arrives on the frame boundary.

// File: rtl/e3_slave_payload_in.sv
module e3_slave_payload_in #(
  parameter int FRAME_BITS = 1536,
  parameter int OH_BITS    = 12,
  localparam int POS_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             fref_in,
  output logic             oh_warn,
  output logic             pay_valid,
  output logic             pay_bit,
  output logic [POS_W-1:0] pay_pos,
  output logic             realign_seen
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] OH_END   = POS_W'(OH_BITS);

  logic             fref_q;
  logic             running;
  logic [POS_W-1:0] cnt;
  logic [POS_W-1:0] cur_pos;
  logic [POS_W-1:0] nxt_pos;
  logic             rise;
  logic             active;
  logic             cur_oh;

  assign rise    = fref_in & ~fref_q;
  assign active  = rise | running;
  assign cur_pos = rise ? '0 : cnt;
  assign nxt_pos = (cur_pos == LAST_POS) ? '0 : cur_pos + POS_W'(1);
  assign cur_oh  = cur_pos < OH_END;
  assign oh_warn = active && (nxt_pos < OH_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fref_q       <= 1'b0;
      running      <= 1'b0;
      cnt          <= '0;
      realign_seen <= 1'b0;
      pay_valid    <= 1'b0;
      pay_bit      <= 1'b0;
      pay_pos      <= '0;
    end else begin
      fref_q    <= fref_in;
      pay_valid <= active && !cur_oh;
      if (rise)
        running <= 1'b1;
      if (rise && running && cnt != '0)
        realign_seen <= 1'b1;
      if (active) begin
        cnt     <= nxt_pos;
        pay_pos <= cur_pos;
      end
      if (active && !cur_oh)
        pay_bit <= ser_in;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !fref_in) |=> !pay_valid); // R1

  AST_REF_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (pay_pos == '0 && !pay_valid)); // R2

  AST_WARN_LEADS_OH: assert property (@(posedge clk) disable iff (!rst_n)
    oh_warn |-> ##2 (!pay_valid && pay_pos < OH_END)); // R6

  AST_PAYLOAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_valid && $past(pay_valid)) |-> (pay_pos == $past(pay_pos) + POS_W'(1))); // R5

  AST_STICKY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    realign_seen |=> realign_seen); // R8

endmodule

// File: tb/test_e3_slave_payload_in.sv
module test_e3_slave_payload_in;
  localparam int FRAME = 1536;
  localparam int OH    = 12;
  localparam int PW    = $clog2(FRAME);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ser_in = 1'b0;
  logic          fref_in = 1'b0;
  logic          oh_warn;
  logic          pay_valid;
  logic          pay_bit;
  logic [PW-1:0] pay_pos;
  logic          realign_seen;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int m_pos = 0;
  bit m_run = 1'b0;
  bit m_prevf = 1'b0;
  bit m_realign = 1'b0;

  e3_slave_payload_in #(.FRAME_BITS(FRAME), .OH_BITS(OH)) i_e3_slave_payload_in (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .fref_in(fref_in),
    .oh_warn(oh_warn), .pay_valid(pay_valid), .pay_bit(pay_bit),
    .pay_pos(pay_pos), .realign_seen(realign_seen)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; fref_in = 1'b0; ser_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_pos = 0; m_run = 1'b0; m_prevf = 1'b0; m_realign = 1'b0;
  endtask

  task automatic step(input logic s, input logic f);
    bit rs, act;
    int p, nx;
    @(negedge clk);
    ser_in = s; fref_in = f;
    rs  = f && !m_prevf;
    p   = rs ? 0 : m_pos;
    act = rs || m_run;
    nx  = (p == FRAME - 1) ? 0 : p + 1;
    #1;
    chk("R6 oh_warn", int'(oh_warn), int'(act && nx < OH));
    if (rs && m_run && m_pos != 0) m_realign = 1'b1;
    @(posedge clk);
    #1;
    chk("R3 pay_valid", int'(pay_valid), int'(act && p >= OH));
    if (act) chk("R5 pay_pos", int'(pay_pos), p);
    if (act && p >= OH) chk("R4 pay_bit", int'(pay_bit), int'(s));
    chk("R7 realign_seen", int'(realign_seen), int'(m_realign));
    m_prevf = f;
    if (rs) m_run = 1'b1;
    if (act) m_pos = nx;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'($urandom_range(0, 1)), 1'b0);
  endtask

  task automatic t_idle();
    do_reset();
    #1;
    chk("R1 reset oh_warn", int'(oh_warn), 0);
    chk("R1 reset realign_seen", int'(realign_seen), 0);
    run(40);
    chk("R1 idle pay_valid", int'(pay_valid), 0);
  endtask

  task automatic t_first_frame();
    step(1'b1, 1'b1);
    chk("R2 first position", int'(pay_pos), 0);
    run(FRAME + 30);
    chk("R5 wrapped position", int'(pay_pos), 30);
    chk("R7 no realign on first ref", int'(realign_seen), 0);
  endtask

  task automatic t_aligned_ref();
    while (m_pos != 0) step(1'($urandom_range(0, 1)), 1'b0);
    step(1'b0, 1'b1);
    chk("R7 boundary ref no flag", int'(realign_seen), 0);
    run(50);
  endtask

  task automatic t_midframe();
    run(100);
    step(1'b1, 1'b1);
    chk("R7 mid-frame flag", int'(realign_seen), 1);
    chk("R2 realigned position", int'(pay_pos), 0);
    run(60);
  endtask

  task automatic t_sticky();
    while (m_pos != 0) step(1'($urandom_range(0, 1)), 1'b0);
    step(1'b0, 1'b1);
    run(300);
    chk("R8 flag held", int'(realign_seen), 1);
    do_reset();
    #1;
    chk("R8 reset clears flag", int'(realign_seen), 0);
  endtask

  task automatic t_held_ref();
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1);
    chk("R2 held ref no retrigger", int'(pay_pos), 3);
    run(40);
    chk("R7 held ref no flag", int'(realign_seen), 0);
  endtask

  initial begin
    t_idle();
    t_first_frame();
    t_aligned_ref();
    t_midframe();
    t_sticky();
    t_held_ref();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule